// File: doc/BRIEF.md
# Frame-Strobe Power-Up Sequencer

This block watches the frame strobe of a voice channel, nominally 8 kHz, which is the only timing reference the channel receives. It measures the strobe with a much faster system clock. From that measurement and a lock flag from the timing generator, it drives four level outputs that power and enable the channel.

While no strobe arrives, the channel stays powered down and its reset is held. When a rising strobe edge appears, the offset-cancellation loop is powered at once in its wide-bandwidth setting, and the channel stays disabled and in reset. The lock flag is resynchronised and must be seen high at a run of consecutive strobe edges. After that, the reset is released and the channel is enabled. In the same cycle the offset loop drops to narrow bandwidth. If the strobe goes missing for longer than a programmable timeout, the block returns to power-down and re-arms wide bandwidth and lock qualification for the next wake-up.

Top module: `strobe_pwr_seq`

## Requirements
- R1: After reset the outputs are pwr_down_o=1, chip_en_o=0, chan_rst_no=0 and bw_wide_o=1.
- R2: The first rising strobe edge seen after power-down leads, within four clock edges, to pwr_down_o=0 and bw_wide_o=1, while chip_en_o stays 0 and chan_rst_no stays 0.
- R3: When TIMEOUT_CLKS system clocks pass with no rising strobe edge, the block returns to pwr_down_o=1, chip_en_o=0, chan_rst_no=0 and bw_wide_o=1, from any state. A gap shorter than the timeout has no effect.
- R4: pll_lock_i passes through a two-flop synchroniser. The reset is released and the channel enabled (chan_rst_no=1, chip_en_o=1) only after LOCK_STROBES consecutive rising strobe edges with the synchronised lock high. With fewer such edges the block stays in the wake state of R2.
- R5: If the synchronised lock goes low during qualification, the count of qualifying edges restarts from zero.
- R6: chip_en_o rises in the same cycle that bw_wide_o falls, and bw_wide_o is 0 whenever chip_en_o is 1.
- R7: Once the channel is enabled, a loss of lock has no effect for as long as the strobe edges keep arriving within the timeout.
- R8: After a return to power-down, the next wake-up needs a full fresh run of LOCK_STROBES qualifying edges before the channel is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the strobe |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Asynchronous frame strobe; only rising edges count |
| pll_lock_i | input | 1 | Lock flag from the timing generator, asynchronous |
| pwr_down_o | output | 1 | 1 while the channel is powered down |
| chip_en_o | output | 1 | 1 while the channel is enabled |
| chan_rst_no | output | 1 | Power-on reset to the channel, active low |
| bw_wide_o | output | 1 | Offset-loop bandwidth: 1 = wide, 0 = narrow |

## Verification
A table of runs covers the following patterns, each started from reset with a given number of strobes and a fixed lock level:
- zero strobes;
- a single strobe;
- one strobe short of the lock run;
- exactly the lock run;
- more than the lock run;
- a long strobe train with lock held low.

Together these separate "still powered down", "woken but held in reset" and "enabled". They also show that the edge count, not the strobe presence alone, releases the reset.

Directed sequences then cover the following:
- a lock drop in the middle of the count, which has to restart the run;
- a lock drop after enable, which has to be ignored;
- a strobe gap sampled just inside and well past the timeout;
- a wake-up after loss, which must not reuse the old count.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic pwr_down;
    logic chip_en;
    logic rst_n;
    logic bw_wide;
  } seq_out_t;

  function automatic seq_out_t decode_state(seq_state_e st);
    seq_out_t o;
    unique case (st)
      ST_WAKE: o = '{pwr_down: 1'b0, chip_en: 1'b0, rst_n: 1'b0, bw_wide: 1'b1};
      ST_RUN:  o = '{pwr_down: 1'b0, chip_en: 1'b1, rst_n: 1'b1, bw_wide: 1'b0};
      default: o = '{pwr_down: 1'b1, chip_en: 1'b0, rst_n: 1'b0, bw_wide: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/psq_rise.sv
module psq_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/psq_strobe_watch.sv
module psq_strobe_watch #(
  parameter int unsigned TIMEOUT_CLKS = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic present_o
);

  localparam int unsigned CW = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CLKS);

  logic [CW-1:0] gap_q;

  // counter parked at LIMIT means "absent"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= LIMIT;
    else if (rise_i)        gap_q <= '0;
    else if (gap_q != LIMIT) gap_q <= gap_q + 1'b1;
  end

  assign present_o = (gap_q != LIMIT);

endmodule

// File: rtl/psq_lock_qual.sv
module psq_lock_qual #(
  parameter int unsigned LOCK_STROBES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic rise_i,
  input  logic present_i,
  output logic qualified_o
);

  localparam int unsigned QW = $clog2(LOCK_STROBES + 1);
  localparam logic [QW-1:0] FULL = QW'(LOCK_STROBES);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            run_q <= '0;
    else if (!lock_i || (!present_i && !rise_i)) run_q <= '0;
    else if (rise_i && run_q != FULL)        run_q <= run_q + 1'b1;
  end

  assign qualified_o = (run_q == FULL);

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import pwrseq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     present_i,
  input  logic     qualified_i,
  output seq_out_t out_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (present_i) state_d = ST_WAKE;
      ST_WAKE: begin
        if (!present_i)       state_d = ST_OFF;
        else if (qualified_i) state_d = ST_RUN;
      end
      ST_RUN:  if (!present_i) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign out_o = decode_state(state_q);

endmodule

// File: rtl/strobe_pwr_seq.sv
module strobe_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 25000,
  parameter int unsigned LOCK_STROBES = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pll_lock_i,
  output logic pwr_down_o,
  output logic chip_en_o,
  output logic chan_rst_no,
  output logic bw_wide_o
);

  logic     strobe_sync;
  logic     strobe_rise;
  logic     lock_sync;
  logic     strobe_present;
  logic     lock_qualified;
  seq_out_t seq_out;

  psq_sync #(.STAGES(SYNC_STAGES)) i_strobe_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(strobe_i), .q_o(strobe_sync)
  );

  psq_rise i_strobe_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(strobe_sync), .rise_o(strobe_rise)
  );

  psq_sync #(.STAGES(SYNC_STAGES)) i_lock_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pll_lock_i), .q_o(lock_sync)
  );

  psq_strobe_watch #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) i_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(strobe_rise), .present_o(strobe_present)
  );

  psq_lock_qual #(.LOCK_STROBES(LOCK_STROBES)) i_lock_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_sync), .rise_i(strobe_rise),
    .present_i(strobe_present), .qualified_o(lock_qualified)
  );

  psq_fsm i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .present_i(strobe_present),
    .qualified_i(lock_qualified), .out_o(seq_out)
  );

  assign pwr_down_o  = seq_out.pwr_down;
  assign chip_en_o   = seq_out.chip_en;
  assign chan_rst_no = seq_out.rst_n;
  assign bw_wide_o   = seq_out.bw_wide;

endmodule

// File: rtl/strobe_pwr_seq_chk.sv
module strobe_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic present,
  input logic lock_sync,
  input logic qualified,
  input logic pwr_down_o,
  input logic chip_en_o,
  input logic chan_rst_no,
  input logic bw_wide_o
);

  a_r2_wake_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_down_o) |-> (bw_wide_o && !chip_en_o && !chan_rst_no));

  a_r3_down_on_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> !$past(present));

  a_r4_enable_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_en_o) |-> ($past(qualified) && $past(lock_sync)));

  a_r4_through_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_en_o) |-> !$past(pwr_down_o));

  a_r6_narrow_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chip_en_o) |-> $fell(bw_wide_o));

  a_r7_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_en_o && present) |=> chip_en_o);

endmodule

bind strobe_pwr_seq strobe_pwr_seq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .present(strobe_present), .lock_sync(lock_sync),
  .qualified(lock_qualified), .pwr_down_o(pwr_down_o), .chip_en_o(chip_en_o),
  .chan_rst_no(chan_rst_no), .bw_wide_o(bw_wide_o)
);

// File: tb/test_strobe_pwr_seq.sv
module test_strobe_pwr_seq;

  localparam int unsigned TMO  = 50;
  localparam int unsigned NLCK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic lock = 1'b0;
  logic pd, en, rstn, wide;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_pwr_seq #(.TIMEOUT_CLKS(TMO), .LOCK_STROBES(NLCK)) i_strobe_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .pll_lock_i(lock),
    .pwr_down_o(pd), .chip_en_o(en), .chan_rst_no(rstn), .bw_wide_o(wide)
  );

  // expected nibble {pd,en,rstn,wide}
  localparam logic [3:0] E_OFF  = 4'b1001;
  localparam logic [3:0] E_WAKE = 4'b0001;
  localparam logic [3:0] E_RUN  = 4'b0110;

  // {strobe count[3:0], lock, expected[3:0]}
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {4'd0, 1'b1, E_OFF},
    {4'd1, 1'b0, E_WAKE},
    {4'd3, 1'b1, E_WAKE},
    {4'd4, 1'b1, E_RUN},
    {4'd6, 1'b1, E_RUN},
    {4'd6, 1'b0, E_WAKE}
  };
  localparam string VTAG [NV] = '{"R1", "R2", "R4", "R4", "R6", "R4"};

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    strobe = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  // one strobe frame: 5 high, 15 low
  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      wait_clk(5);
      strobe = 1'b0;
      wait_clk(15);
    end
  endtask

  task automatic check(string tag, logic [3:0] exp);
    n_chk++;
    if ({pd, en, rstn, wide} !== exp) begin
      n_bad++;
      $display("FAIL %s: got pd/en/rstn/wide=%b expected %b", tag, {pd, en, rstn, wide}, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_clk(2);
    check("R1", E_OFF);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1", E_OFF);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      lock = VEC[v][4];
      wait_clk(4);
      strobes(int'(VEC[v][8:5]));
      check(VTAG[v], VEC[v][3:0]);
    end

    // R2 exact wake timing: rise seen within four edges
    do_reset();
    lock = 1'b0;
    strobe = 1'b1;
    wait_clk(4);
    check("R2", E_WAKE);
    strobe = 1'b0;
    wait_clk(15);

    // R5 lock drop mid-count restarts the run
    do_reset();
    lock = 1'b1;
    wait_clk(4);
    strobes(3);
    lock = 1'b0;
    wait_clk(5);
    lock = 1'b1;
    wait_clk(5);
    strobes(3);
    check("R5", E_WAKE);
    strobes(1);
    check("R5", E_RUN);

    // R7 lock loss while running is ignored
    lock = 1'b0;
    strobes(3);
    check("R7", E_RUN);

    // R3 gap inside timeout: no effect; beyond: power down
    wait_clk(20);
    check("R3", E_RUN);
    wait_clk(40);
    check("R3", E_OFF);

    // R8 wake-up after loss needs fresh qualification
    lock = 1'b1;
    wait_clk(4);
    strobes(1);
    check("R8", E_WAKE);
    strobes(2);
    check("R8", E_WAKE);
    strobes(1);
    check("R8", E_RUN);

    // R3 loss from wake state
    do_reset();
    lock = 1'b0;
    strobes(2);
    check("R3", E_WAKE);
    wait_clk(60);
    check("R3", E_OFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule